// File: doc/BRIEF.md
# AC-link input frame serializer

This block is the codec-side transmitter of the serial frame that travels from codec to controller on an AC-link. It runs on the bit clock supplied to the link. It follows the frame alignment that the controller marks with its SYNC pulse, and it drives the codec's serial data output one bit per bit-clock period. Each frame is 256 bits long. It opens with a 16-bit tag slot and continues with twelve 20-bit slots.

The tag slot carries several flags. One says the codec is ready. Others mark which slots hold data. The slots carry a register read-back address and data pair and the left and right capture PCM samples. All payload inputs are sampled once, on the rising bit-clock edge that places the first frame bit on the line. Changes to them during the frame are not seen until the next frame. Any bit that has no meaning, and every bit of a slot flagged as empty, is driven low.

The control is a small state machine. In state `S_WAIT_SYNC` the line is held low until the first frame start after reset. In state `S_SHIFT` the held frame is shifted out. In state `S_DONE` the last bit has been sent and the line stays low. The transitions are as follows. `S_WAIT_SYNC` goes to `S_SHIFT` on a frame start. `S_SHIFT` goes to `S_DONE` after bit 255 if no new frame start arrives. `S_SHIFT` and `S_DONE` both return to the start of `S_SHIFT` on any frame start. A frame start is a low-to-high change of SYNC between two successive falling-edge samples.

Top module: `ac_in_frame_serializer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first frame start, `sdata_in` is 0.
- R2: When SYNC is sampled high on a falling edge after being sampled low on the previous falling edge, the next rising edge drives frame bit 0, and that bit equals `codec_ready`.
- R3: Frame bits 1 and 2 both equal `rd_valid`. Bit 3 equals `cap_left_valid` and bit 4 equals `cap_right_valid`. Bits 5 to 15 are 0.
- R4: Bits 16 to 35 form the address slot. Bit 16 is 0. Bits 17 to 23 carry `rd_addr` with its most significant bit first. Bits 24 to 35 are 0. The whole slot is 0 when `rd_valid` is low.
- R5: Bits 36 to 55 carry `rd_data` with its most significant bit first in bits 36 to 51, and bits 52 to 55 are 0. The whole slot is 0 when `rd_valid` is low.
- R6: Bits 56 to 73 carry `cap_left` with its most significant bit first, and bits 74 to 75 are 0. Bits 76 to 93 carry `cap_right` in the same way, and bits 94 to 95 are 0. Each of these slots is 0 when its valid flag is low.
- R7: Bits 96 to 255, which are the eight unused slots, are 0.
- R8: Payload inputs are taken on the rising edge that drives bit 0. Changing them later in the frame does not alter the bits sent.
- R9: After bit 255, if no new frame start has been detected, `sdata_in` stays 0 until one is detected.
- R10: A frame start detected at any point, including mid-frame, restarts the frame at bit 0 with freshly taken payload. SYNC held high across many bits causes no further restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; data changes on its rising edge, SYNC is sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker from the controller |
| codec_ready | input | 1 | Codec-ready flag placed in bit 0 |
| rd_valid | input | 1 | Marks the address and data slots as valid |
| rd_addr | input | 7 | Register read-back address |
| rd_data | input | 16 | Register read-back data |
| cap_left_valid | input | 1 | Marks the left capture slot as valid |
| cap_left | input | 18 | Left capture sample |
| cap_right_valid | input | 1 | Marks the right capture slot as valid |
| cap_right | input | 18 | Right capture sample |
| sdata_in | output | 1 | Serial frame output toward the controller |

## Verification
On every cycle, the assertions check the following. The line is quiet before the first frame and after bit 255. Bit 0 follows the codec-ready flag. The first slot flag follows the read-back valid input. The tag padding, the reserved bit of the address slot and the eight spare slots stay low. The bit counter advances one step per edge and restarts at every frame start. Only the bench's scenarios can show that the address, data and PCM fields arrive in full, most significant bit first, for every combination of valid flags. The bench scenarios also show that inputs scrambled mid-frame leave the frame intact, that back-to-back frames join without a gap, and that a SYNC raised mid-frame yields a clean new frame.

// File: rtl/ac_in_pkg.sv
`timescale 1ns/1ps
package ac_in_pkg;
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int DATA_SLOTS = 12;

    typedef enum logic [1:0] {
        S_WAIT_SYNC = 2'd0,
        S_SHIFT     = 2'd1,
        S_DONE      = 2'd2
    } ser_state_e;
endpackage

// File: rtl/ac_in_sync_detect.sv
`timescale 1ns/1ps
module ac_in_sync_detect (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic sync,
    output logic frame_start
);
    logic samp_now;
    logic samp_prev;

    // SYNC is sampled on the falling edge of the bit clock
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_now  <= 1'b0;
            samp_prev <= 1'b0;
        end else begin
            samp_now  <= sync;
            samp_prev <= samp_now;
        end
    end

    // high for exactly one following rising edge per low-to-high change
    assign frame_start = samp_now & ~samp_prev;
endmodule

// File: rtl/ac_in_frame_builder.sv
`timescale 1ns/1ps
module ac_in_frame_builder #(
    parameter int TAG_W     = ac_in_pkg::TAG_BITS,
    parameter int SLOT_W    = ac_in_pkg::SLOT_BITS,
    parameter int NUM_SLOTS = ac_in_pkg::DATA_SLOTS,
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 16,
    parameter int PCM_W     = 18,
    localparam int FRAME_W  = TAG_W + NUM_SLOTS * SLOT_W
) (
    input  logic              codec_ready,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              l_valid,
    input  logic [PCM_W-1:0]  left,
    input  logic              r_valid,
    input  logic [PCM_W-1:0]  right,
    output logic [FRAME_W-1:0] frame
);
    localparam int ADDR_PAD = SLOT_W - 1 - ADDR_W;
    localparam int DATA_PAD = SLOT_W - DATA_W;
    localparam int PCM_PAD  = SLOT_W - PCM_W;

    logic [SLOT_W-1:0] slot_word [NUM_SLOTS];

    // tag slot: bit 0 of the frame is the top bit of the vector
    assign frame[FRAME_W-1 -: TAG_W] =
        {codec_ready, rd_valid, rd_valid, l_valid, r_valid, {(TAG_W-5){1'b0}}};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_addr
            assign slot_word[s] = rd_valid ? {1'b0, rd_addr, {ADDR_PAD{1'b0}}} : '0;
        end else if (s == 1) begin : g_data
            assign slot_word[s] = rd_valid ? {rd_data, {DATA_PAD{1'b0}}} : '0;
        end else if (s == 2) begin : g_left
            assign slot_word[s] = l_valid ? {left, {PCM_PAD{1'b0}}} : '0;
        end else if (s == 3) begin : g_right
            assign slot_word[s] = r_valid ? {right, {PCM_PAD{1'b0}}} : '0;
        end else begin : g_spare
            assign slot_word[s] = '0;
        end
        assign frame[FRAME_W-1-TAG_W-s*SLOT_W -: SLOT_W] = slot_word[s];
    end
endmodule

// File: rtl/ac_in_frame_serializer.sv
`timescale 1ns/1ps
module ac_in_frame_serializer #(
    parameter int TAG_W     = ac_in_pkg::TAG_BITS,
    parameter int SLOT_W    = ac_in_pkg::SLOT_BITS,
    parameter int NUM_SLOTS = ac_in_pkg::DATA_SLOTS,
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 16,
    parameter int PCM_W     = 18
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              codec_ready,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              cap_left_valid,
    input  logic [PCM_W-1:0]  cap_left,
    input  logic              cap_right_valid,
    input  logic [PCM_W-1:0]  cap_right,
    output logic              sdata_in
);
    import ac_in_pkg::*;

    localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic               frame_start;
    logic [FRAME_W-1:0] frame_bits;
    logic [FRAME_W-1:0] shreg;
    logic [IDX_W-1:0]   bit_idx;
    logic               sdata_q;
    ser_state_e         state_q;
    ser_state_e         state_d;

    ac_in_sync_detect u_sync (
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .frame_start (frame_start)
    );

    ac_in_frame_builder #(
        .TAG_W     (TAG_W),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PCM_W     (PCM_W)
    ) u_build (
        .codec_ready (codec_ready),
        .rd_valid    (rd_valid),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .l_valid     (cap_left_valid),
        .left        (cap_left),
        .r_valid     (cap_right_valid),
        .right       (cap_right),
        .frame       (frame_bits)
    );

    // state register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_WAIT_SYNC;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_WAIT_SYNC: if (frame_start) state_d = S_SHIFT;
            S_SHIFT: begin
                if (frame_start)             state_d = S_SHIFT;
                else if (bit_idx == LAST_IDX) state_d = S_DONE;
            end
            S_DONE:      if (frame_start) state_d = S_SHIFT;
            default:     state_d = S_WAIT_SYNC;
        endcase
    end

    // output and shift path: bit k goes out on the edge where bit_idx == k
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
            sdata_q <= 1'b0;
        end else if (frame_start) begin
            sdata_q <= frame_bits[FRAME_W-1];
            shreg   <= {frame_bits[FRAME_W-2:0], 1'b0};
            bit_idx <= IDX_W'(1);
        end else begin
            unique case (state_q)
                S_SHIFT: begin
                    sdata_q <= shreg[FRAME_W-1];
                    shreg   <= {shreg[FRAME_W-2:0], 1'b0};
                    bit_idx <= bit_idx + IDX_W'(1);
                end
                default: begin
                    sdata_q <= 1'b0;
                    bit_idx <= '0;
                end
            endcase
        end
    end

    assign sdata_in = sdata_q;
endmodule

// File: rtl/ac_in_frame_serializer_chk.sv
`timescale 1ns/1ps
module ac_in_frame_serializer_chk #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int IDX_W  = 8,
    parameter int FRAME_W = 256
) (
    input logic                   bit_clk,
    input logic                   rst_n,
    input logic                   frame_start,
    input ac_in_pkg::ser_state_e  state_q,
    input logic [IDX_W-1:0]       bit_idx,
    input logic                   sdata_in,
    input logic                   codec_ready,
    input logic                   rd_valid
);
    import ac_in_pkg::*;

    localparam logic [IDX_W-1:0] PAD_LO    = IDX_W'(5);
    localparam logic [IDX_W-1:0] TAG_END   = IDX_W'(TAG_W);
    localparam logic [IDX_W-1:0] SPARE_LO  = IDX_W'(TAG_W + 4 * SLOT_W);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_W - 1);

    assert_wait_quiet_R1: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == S_WAIT_SYNC && !frame_start) |=> (sdata_in == 1'b0));

    assert_first_bit_ready_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_start |=> (sdata_in == $past(codec_ready)));

    assert_slot1_flag_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (frame_start ##1 !frame_start) |=> (sdata_in == $past(rd_valid, 2)));

    assert_tag_pad_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == S_SHIFT && !frame_start && bit_idx >= PAD_LO && bit_idx < TAG_END)
        |=> (sdata_in == 1'b0));

    assert_addr_reserved_R4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == S_SHIFT && !frame_start && bit_idx == TAG_END) |=> (sdata_in == 1'b0));

    assert_spare_slots_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == S_SHIFT && !frame_start && bit_idx >= SPARE_LO) |=> (sdata_in == 1'b0));

    assert_done_quiet_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == S_DONE && !frame_start) |=> (sdata_in == 1'b0));

    assert_restart_R10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_start |=> (state_q == S_SHIFT && bit_idx == IDX_W'(1)));

    assert_idx_advance_R10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == S_SHIFT && !frame_start && bit_idx != LAST_IDX)
        |=> (state_q == S_SHIFT && bit_idx == $past(bit_idx) + IDX_W'(1)));
endmodule

bind ac_in_frame_serializer ac_in_frame_serializer_chk #(
    .TAG_W   (TAG_W),
    .SLOT_W  (SLOT_W),
    .IDX_W   (IDX_W),
    .FRAME_W (FRAME_W)
) u_chk (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .state_q     (state_q),
    .bit_idx     (bit_idx),
    .sdata_in    (sdata_in),
    .codec_ready (codec_ready),
    .rd_valid    (rd_valid)
);

// File: tb/ac_in_frame_serializer_tb.sv
`timescale 1ns/1ps
module ac_in_frame_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic        rd_valid = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data = '0;
    logic        cap_left_valid = 1'b0;
    logic [17:0] cap_left = '0;
    logic        cap_right_valid = 1'b0;
    logic [17:0] cap_right = '0;
    logic        sdata_in;

    int n_checks = 0;
    int n_fail   = 0;

    // snapshot of the payload expected in the frame being observed
    logic        e_rdy, e_rv, e_lv, e_rrv;
    logic [6:0]  e_addr;
    logic [15:0] e_data;
    logic [17:0] e_left, e_right;

    always #2.5 clk = ~clk;

    ac_in_frame_serializer u_dut (
        .bit_clk         (clk),
        .rst_n           (rst_n),
        .sync            (sync),
        .codec_ready     (codec_ready),
        .rd_valid        (rd_valid),
        .rd_addr         (rd_addr),
        .rd_data         (rd_data),
        .cap_left_valid  (cap_left_valid),
        .cap_left        (cap_left),
        .cap_right_valid (cap_right_valid),
        .cap_right       (cap_right),
        .sdata_in        (sdata_in)
    );

    function automatic logic exp_bit(int p);
        int o;
        if (p == 0) return e_rdy;
        if (p == 1 || p == 2) return e_rv;
        if (p == 3) return e_lv;
        if (p == 4) return e_rrv;
        if (p < 16) return 1'b0;
        if (p < 36) begin
            o = p - 16;
            return (o >= 1 && o <= 7) ? (e_rv & e_addr[7 - o]) : 1'b0;
        end
        if (p < 56) begin
            o = p - 36;
            return (o < 16) ? (e_rv & e_data[15 - o]) : 1'b0;
        end
        if (p < 76) begin
            o = p - 56;
            return (o < 18) ? (e_lv & e_left[17 - o]) : 1'b0;
        end
        if (p < 96) begin
            o = p - 76;
            return (o < 18) ? (e_rrv & e_right[17 - o]) : 1'b0;
        end
        return 1'b0;
    endfunction

    function automatic string req_of(int p);
        if (p == 0) return "R2";
        if (p < 16) return "R3";
        if (p < 36) return "R4";
        if (p < 56) return "R5";
        if (p < 96) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, int p, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at bit %0d: actual %b expected %b", req, p, act, exp);
        end
    endtask

    task automatic apply(logic rdy, logic rv, logic lv, logic rrv,
                         logic [6:0] a, logic [15:0] d, logic [17:0] l, logic [17:0] r);
        codec_ready = rdy; rd_valid = rv; cap_left_valid = lv; cap_right_valid = rrv;
        rd_addr = a; rd_data = d; cap_left = l; cap_right = r;
    endtask

    task automatic invert_inputs();
        codec_ready = ~codec_ready; rd_valid = ~rd_valid;
        cap_left_valid = ~cap_left_valid; cap_right_valid = ~cap_right_valid;
        rd_addr = ~rd_addr; rd_data = ~rd_data; cap_left = ~cap_left; cap_right = ~cap_right;
    endtask

    // call just after a negedge: DUT sees SYNC high on the next negedge
    task automatic begin_sync();
        #1 sync = 1'b1;
        @(negedge clk);
    endtask

    // observes bits 0..nbits-1; entered right after the negedge where SYNC was sampled
    task automatic run_frame(bit chain, bit scramble, int nbits);
        e_rdy = codec_ready; e_rv = rd_valid; e_lv = cap_left_valid; e_rrv = cap_right_valid;
        e_addr = rd_addr; e_data = rd_data; e_left = cap_left; e_right = cap_right;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            check(scramble ? {"R8/", req_of(k)} : req_of(k), k, sdata_in, exp_bit(k));
            if (k == 3 || k == 15 || k == 254) begin
                #1;
                if (k == 3 && scramble) invert_inputs();
                if (k == 15) sync = 1'b0;
                if (k == 254 && scramble) invert_inputs();
                if (k == 254 && chain) sync = 1'b1;
            end
        end
    endtask

    task automatic check_quiet(string req, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(req, -1, sdata_in, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1: actual hung, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: quiet in reset and before any SYNC, even with busy inputs
        apply(1'b1, 1'b1, 1'b1, 1'b1, 7'h7F, 16'hFFFF, 18'h3FFFF, 18'h3FFFF);
        check_quiet("R1", 6);
        #1 rst_n = 1'b1;
        check_quiet("R1", 20);

        // sweep all flag combinations, frames back to back (R2..R8)
        apply(1'b0, 1'b0, 1'b0, 1'b0, 7'd0, 16'd0, 18'd0, 18'd0);
        begin_sync();
        for (int i = 0; i < 32; i++) begin
            apply(i[0], i[1], i[2], i[3],
                  7'((i * 37 + 5) % 128),
                  16'(i * 16'h1357) ^ 16'hA5C3,
                  18'(i * 18'h2345 + 1),
                  18'(~(i * 18'h0F0F)));
            run_frame(i < 31, (i % 3) == 0, 256);
        end

        // R9: no new SYNC after bit 255
        check_quiet("R9", 40);

        // R10: restart part-way through a frame
        apply(1'b1, 1'b1, 1'b1, 1'b1, 7'h55, 16'hC3A5, 18'h2AAAA, 18'h15555);
        begin_sync();
        run_frame(1'b0, 1'b0, 101);
        #1 sync = 1'b1;
        apply(1'b1, 1'b1, 1'b0, 1'b1, 7'h2A, 16'h8001, 18'h3FFFF, 18'h20001);
        @(negedge clk);
        run_frame(1'b0, 1'b0, 256);
        check_quiet("R10/R9", 10);

        // extremes: all ones with every slot valid, then all ones with none valid
        apply(1'b1, 1'b1, 1'b1, 1'b1, 7'h7F, 16'hFFFF, 18'h3FFFF, 18'h3FFFF);
        begin_sync();
        run_frame(1'b1, 1'b1, 256);
        apply(1'b0, 1'b0, 1'b0, 1'b0, 7'h7F, 16'hFFFF, 18'h3FFFF, 18'h3FFFF);
        run_frame(1'b0, 1'b0, 256);
        check_quiet("R9", 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule